// File: doc/BRIEF.md
# Console Input Source Router

This block connects two character sources to the keyboard port of a small retro computer. One source is a stream of ASCII bytes decoded from a PS/2 keyboard, one byte per valid strobe; the other is the byte stream from a UART receiver. A select input decides which source may load the single-byte keyboard holding register. The register is read by the CPU through a ready flag and a data byte.

Keys typed on the PS/2 path are folded to capitals, because the monitor program understands only capitals. Serial bytes pass through untouched. Every byte the CPU writes to its display port is also copied to the UART transmit side, whichever source is selected. An active-low clear-to-send output holds off the serial host while a byte waits in the register. This lets a host paste long text into the machine over a 115200 baud 8N1 link without losing characters. The serializer, the deserializer, the scan-code decoder and the CPU lie outside this block.

Top module: `con_router`

## Requirements
- R1: With `sel_uart` = 0 only PS/2 strobes load the register. With `sel_uart` = 1 only UART strobes load it. A strobe from the other source is discarded and leaves `kbd_ready` at 0.
- R2: A PS/2 byte from 0x61 to 0x7A inclusive is presented with 0x20 subtracted. PS/2 bytes outside that range, such as 0x60 and 0x7B, keep their low seven bits.
- R3: A UART byte is presented with its low seven bits unchanged, so lowercase stays lowercase.
- R4: Bit 7 of `kbd_data` is 1 whenever `kbd_ready` is 1.
- R5: An accepted strobe sets `kbd_ready` on the next clock edge. A `kbd_rd` pulse clears it on the next edge.
- R6: A strobe that arrives while `kbd_ready` is 1 is dropped. `kbd_data` keeps the earlier byte.
- R7: `cts_n` is 1 exactly while `kbd_ready` is 1. It returns to 0 one clock after the `kbd_rd` pulse.
- R8: A `dsp_wr` pulse produces a one-cycle `tx_valid` on the next edge, with `tx_byte` equal to `dsp_byte`. This holds under either select setting.
- R9: After reset, `kbd_ready` = 0, `cts_n` = 0 and `tx_valid` = 0.
- R10: A strobe in the same cycle as `kbd_rd` is dropped, and `kbd_ready` reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_uart | input | 1 | 0 selects PS/2, 1 selects UART |
| ps2_valid | input | 1 | Strobe for a decoded PS/2 character |
| ps2_byte | input | 8 | Decoded PS/2 character |
| urx_valid | input | 1 | Strobe for a received UART byte |
| urx_byte | input | 8 | Received UART byte |
| kbd_rd | input | 1 | CPU read of the keyboard data |
| kbd_ready | output | 1 | A character waits in the register |
| kbd_data | output | 8 | Held character, bit 7 set |
| dsp_wr | input | 1 | CPU write to the display port |
| dsp_byte | input | 8 | Display character |
| tx_valid | output | 1 | Byte for the UART transmitter |
| tx_byte | output | 8 | Mirrored display character |
| cts_n | output | 1 | Active-low clear-to-send to the serial host |

## Verification
Two events can share a cycle: a CPU read and a new source strobe. A display write can also coincide with a key being accepted. The bench loads a byte, then raises `kbd_rd` and `ps2_valid` in the same cycle. It expects `kbd_ready` and `cts_n` at 0 afterwards, with the late byte gone. It also pulses `dsp_wr` in the cycle a key is accepted. Both the mirrored byte and the held key must then appear one edge later, each with its own value.

// File: rtl/con_pkg.sv
package con_pkg;
  parameter int CHAR_W = 8;
  localparam int MARK_BIT = CHAR_W - 1;
  typedef logic [CHAR_W-1:0] char_t;
  localparam char_t LOW_A = char_t'(8'h61);
  localparam char_t LOW_Z = char_t'(8'h7A);
  localparam char_t CASE_GAP = char_t'(8'h20);

  function automatic char_t fold_case(input char_t c);
    if (c >= LOW_A && c <= LOW_Z) return c - CASE_GAP;
    return c;
  endfunction
endpackage

// File: rtl/con_src_mux.sv
module con_src_mux
  import con_pkg::*;
(
  input  logic  sel_uart,
  input  logic  ps2_valid,
  input  char_t ps2_byte,
  input  logic  urx_valid,
  input  char_t urx_byte,
  output logic  pick_valid,
  output char_t pick_byte
);
  // Case folding only on the keyboard path; serial bytes are left alone.
  always_comb begin
    if (sel_uart) begin
      pick_valid = urx_valid;
      pick_byte  = urx_byte;
    end else begin
      pick_valid = ps2_valid;
      pick_byte  = fold_case(ps2_byte);
    end
  end
endmodule

// File: rtl/con_kbd_hold.sv
module con_kbd_hold
  import con_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pick_valid,
  input  char_t pick_byte,
  input  logic  kbd_rd,
  output logic  kbd_ready,
  output char_t kbd_data,
  output logic  cts_n
);
  logic take;
  logic ready_nx;

  // A byte is taken only into an empty register, and never in a read cycle.
  assign take = pick_valid && !kbd_ready && !kbd_rd;

  always_comb begin
    ready_nx = kbd_ready;
    if (kbd_rd) ready_nx = 1'b0;
    else if (take) ready_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kbd_ready <= 1'b0;
      cts_n     <= 1'b0;
      kbd_data  <= '0;
    end else begin
      kbd_ready <= ready_nx;
      cts_n     <= ready_nx;
      if (take) begin
        kbd_data           <= pick_byte;
        kbd_data[MARK_BIT] <= 1'b1;
      end
    end
  end

  assert_bit7_R4: assert property (@(posedge clk) disable iff (rst)
    kbd_ready |-> kbd_data[MARK_BIT]);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (kbd_ready && !kbd_rd) |=> (kbd_ready && $stable(kbd_data)));
  assert_rd_clear_R5: assert property (@(posedge clk) disable iff (rst)
    kbd_rd |=> !kbd_ready);
  assert_cts_R7: assert property (@(posedge clk) disable iff (rst)
    cts_n == kbd_ready);
endmodule

// File: rtl/con_tx_mirror.sv
module con_tx_mirror
  import con_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  dsp_wr,
  input  char_t dsp_byte,
  output logic  tx_valid,
  output char_t tx_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= dsp_wr;
      if (dsp_wr) tx_byte <= dsp_byte;
    end
  end

  assert_mirror_R8: assert property (@(posedge clk) disable iff (rst)
    dsp_wr |=> (tx_valid && tx_byte == $past(dsp_byte)));
  assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    !dsp_wr |=> !tx_valid);
endmodule

// File: rtl/con_router.sv
module con_router
  import con_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_uart,
  input  logic              ps2_valid,
  input  logic [CHAR_W-1:0] ps2_byte,
  input  logic              urx_valid,
  input  logic [CHAR_W-1:0] urx_byte,
  input  logic              kbd_rd,
  output logic              kbd_ready,
  output logic [CHAR_W-1:0] kbd_data,
  input  logic              dsp_wr,
  input  logic [CHAR_W-1:0] dsp_byte,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_byte,
  output logic              cts_n
);
  logic  pick_valid;
  char_t pick_byte;

  con_src_mux mux_i (
    .sel_uart(sel_uart), .ps2_valid(ps2_valid), .ps2_byte(ps2_byte),
    .urx_valid(urx_valid), .urx_byte(urx_byte),
    .pick_valid(pick_valid), .pick_byte(pick_byte)
  );

  con_kbd_hold hold_i (
    .clk(clk), .rst(rst), .pick_valid(pick_valid), .pick_byte(pick_byte),
    .kbd_rd(kbd_rd), .kbd_ready(kbd_ready), .kbd_data(kbd_data), .cts_n(cts_n)
  );

  con_tx_mirror mir_i (
    .clk(clk), .rst(rst), .dsp_wr(dsp_wr), .dsp_byte(dsp_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  // R1: a strobe from the unselected source alone never raises the flag.
  assert_unsel_R1: assert property (@(posedge clk) disable iff (rst)
    (!kbd_ready && !(sel_uart ? urx_valid : ps2_valid)) |=> !kbd_ready);
endmodule

// File: tb/con_router_tb_top.sv
module con_router_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_uart = 1'b0, ps2_valid = 1'b0, urx_valid = 1'b0, kbd_rd = 1'b0, dsp_wr = 1'b0;
  logic [7:0] ps2_byte = '0, urx_byte = '0, dsp_byte = '0;
  logic kbd_ready, tx_valid, cts_n;
  logic [7:0] kbd_data, tx_byte;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  con_router dut_i (
    .clk(clk), .rst(rst), .sel_uart(sel_uart), .ps2_valid(ps2_valid), .ps2_byte(ps2_byte),
    .urx_valid(urx_valid), .urx_byte(urx_byte), .kbd_rd(kbd_rd), .kbd_ready(kbd_ready),
    .kbd_data(kbd_data), .dsp_wr(dsp_wr), .dsp_byte(dsp_byte), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .cts_n(cts_n)
  );

  // {sel_uart, strobe on uart, input byte, expect ready, expected data}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h61, 1'b1, 8'hC1},  // R2 'a'
    {1'b0, 1'b0, 8'h7A, 1'b1, 8'hDA},  // R2 'z'
    {1'b0, 1'b0, 8'h41, 1'b1, 8'hC1},  // R2 'A'
    {1'b0, 1'b0, 8'h7B, 1'b1, 8'hFB},  // R2 above range
    {1'b0, 1'b0, 8'h60, 1'b1, 8'hE0},  // R2 below range
    {1'b1, 1'b1, 8'h61, 1'b1, 8'hE1},  // R3 lowercase kept
    {1'b1, 1'b1, 8'h51, 1'b1, 8'hD1},  // R3
    {1'b0, 1'b1, 8'h61, 1'b0, 8'h00},  // R1 uart ignored
    {1'b1, 1'b0, 8'h61, 1'b0, 8'h00},  // R1 ps2 ignored
    {1'b0, 1'b0, 8'h35, 1'b1, 8'hB5}   // R4 digit
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic strobe(input logic uart, input logic [7:0] b);
    if (uart) begin urx_valid = 1'b1; urx_byte = b; end
    else begin ps2_valid = 1'b1; ps2_byte = b; end
    cyc();
    urx_valid = 1'b0; ps2_valid = 1'b0;
  endtask

  task automatic rd_pulse();
    kbd_rd = 1'b1; cyc(); kbd_rd = 1'b0;
  endtask

  initial begin
    repeat (3) cyc();
    chk("R9 ready", {7'd0, kbd_ready}, 8'd0);
    chk("R9 cts_n", {7'd0, cts_n}, 8'd0);
    chk("R9 tx_valid", {7'd0, tx_valid}, 8'd0);
    rst = 1'b0;
    cyc();

    for (int i = 0; i < NV; i++) begin
      sel_uart = VEC[i][18];
      strobe(VEC[i][17], VEC[i][16:9]);
      chk("R1/R5 ready", {7'd0, kbd_ready}, {7'd0, VEC[i][8]});
      chk("R7 cts_n", {7'd0, cts_n}, {7'd0, VEC[i][8]});
      if (VEC[i][8]) begin
        chk("R2/R3/R4 data", kbd_data, VEC[i][7:0]);
        rd_pulse();
        chk("R5 cleared", {7'd0, kbd_ready}, 8'd0);
        chk("R7 cts back", {7'd0, cts_n}, 8'd0);
      end
    end

    // R6: second byte while full is dropped
    sel_uart = 1'b0;
    strobe(1'b0, 8'h42);
    strobe(1'b0, 8'h43);
    chk("R6 data kept", kbd_data, 8'hC2);
    chk("R6 still ready", {7'd0, kbd_ready}, 8'd1);

    // R10: read and arrival in the same cycle
    kbd_rd = 1'b1; ps2_valid = 1'b1; ps2_byte = 8'h44;
    cyc();
    kbd_rd = 1'b0; ps2_valid = 1'b0;
    chk("R10 ready", {7'd0, kbd_ready}, 8'd0);
    chk("R10 cts_n", {7'd0, cts_n}, 8'd0);
    cyc();
    chk("R10 stays empty", {7'd0, kbd_ready}, 8'd0);

    // R8: mirror under both selects, one in the same cycle as a key
    dsp_wr = 1'b1; dsp_byte = 8'h8D; ps2_valid = 1'b1; ps2_byte = 8'h71;
    cyc();
    dsp_wr = 1'b0; ps2_valid = 1'b0;
    chk("R8 tx_valid", {7'd0, tx_valid}, 8'd1);
    chk("R8 tx_byte", tx_byte, 8'h8D);
    chk("R2 key with write", kbd_data, 8'hD1);
    cyc();
    chk("R8 one pulse", {7'd0, tx_valid}, 8'd0);
    rd_pulse();
    sel_uart = 1'b1;
    dsp_wr = 1'b1; dsp_byte = 8'h3F;
    cyc();
    dsp_wr = 1'b0;
    chk("R8 uart sel tx_byte", tx_byte, 8'h3F);
    chk("R8 uart sel tx_valid", {7'd0, tx_valid}, 8'd1);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule